// File: doc/BRIEF.md
# Translation Cache Invalidation Command Decoder

This block sits between an IOMMU command queue reader and a tagged translation cache. It accepts one two-doubleword invalidation command at a time through a valid/ready handshake. It turns the command into one or two invalidation requests for the cache. Each request carries a match mask that says which fields to compare, a guest ID, a process ID, a page number, and a translation tag. The tag keeps entries that were built by different translation schemes apart.

There are two kinds of command. A guest-physical invalidation always produces two requests that differ only in their tag: the first is tagged second-stage-only and the second is tagged nested. A virtual-address invalidation produces one request, and its tag is picked by the command's guest-valid flag. A command whose function code is not recognised, or whose flags form an illegal combination, produces no request and ends with an illegal-command pulse instead of the completion pulse.

Top module: `tlb_inval_decoder`

## Requirements
- R1: `cmdReady` is high only while the decoder is idle, and a command is taken on a clock edge where `cmdValid` and `cmdReady` are both high. `cmdReady` then stays low until every request for that command has been accepted and the one-cycle ending pulse has been given.
- R2: The function code sits in `cmdWord0[2:0]`. Code 0 means virtual-address invalidation and code 1 means guest-physical invalidation. Any other code raises `illegalPulse` and issues no request.
- R3: A guest-physical invalidation with the process-valid flag (`cmdWord0[9]`) set is illegal: it raises `illegalPulse` and issues no request.
- R4: A legal guest-physical invalidation issues exactly two requests with the same mask, IDs and page. The first carries tag 2 (second-stage-only) and the second carries tag 3 (nested).
- R5: The match mask is encoded as bit 0 = compare guest ID, bit 1 = compare process ID, bit 2 = compare page; a mask of zero invalidates every entry of the tag. For a guest-physical invalidation, guest-valid (`cmdWord0[10]`) clear gives mask 0 whatever the address-valid flag (`cmdWord0[8]`) is. Guest-valid set gives bit 0, plus bit 2 when address-valid is set. Bit 1 is never set.
- R6: A virtual-address invalidation with guest-valid set issues one request with tag 3 and mask bit 0 set. Mask bit 1 follows process-valid and mask bit 2 follows address-valid.
- R7: A virtual-address invalidation with guest-valid clear issues one request with tag 1 (single stage) and mask bit 0 clear. Mask bit 1 follows process-valid and mask bit 2 follows address-valid.
- R8: `reqProcId` is `cmdWord0[31:12]` and `reqGuestId` is `cmdWord0[47:32]`. The target address is `cmdWord1` shifted left by two with its low 12 bits cleared. `reqPage` is that address shifted right by 12, which is `cmdWord1[53:10]`.
- R9: While `reqValid` is high and `reqReady` is low, `reqValid` and every request field hold their values.
- R10: Each command ends with exactly one single-cycle pulse, one cycle after its last request is accepted (or one cycle after acceptance if it is illegal). The pulse is `donePulse` for a legal command and `illegalPulse` for an illegal one, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Decoder can take a command |
| cmdWord0 | input | 64 | First command doubleword: function, flags, IDs |
| cmdWord1 | input | 64 | Second command doubleword: address |
| reqValid | output | 1 | Invalidation request present |
| reqReady | input | 1 | Cache accepts the request |
| reqMask | output | 3 | Match mask {page, process, guest} |
| reqGuestId | output | 16 | Guest ID to compare |
| reqProcId | output | 20 | Process ID to compare |
| reqPage | output | 44 | Page number to compare |
| reqTag | output | 2 | Translation tag of the entries to hit |
| illegalPulse | output | 1 | One-cycle flag for an illegal command |
| donePulse | output | 1 | One-cycle flag for a completed command |

## Verification
The assertions take for granted that the upstream side keeps a command's doublewords steady while it is offered. They also assume `reqReady` is a plain input and is not derived combinationally from `reqValid`. The stimulus drives every input on the falling edge and holds the command words until the decoder has taken them. It stalls the request side only by leaving `reqReady` low for whole cycles, so the hold and ordering properties are exercised only within that contract.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;

  typedef enum logic [1:0] {
    TAG_BYPASS = 2'd0,
    TAG_SINGLE = 2'd1,
    TAG_GSTAGE = 2'd2,
    TAG_NESTED = 2'd3
  } xlat_tag_e;

  localparam int MASK_W   = 3;
  localparam int MB_GUEST = 0;
  localparam int MB_PROC  = 1;
  localparam int MB_ADDR  = 2;

  localparam int FN_W = 3;
  localparam logic [FN_W-1:0] FN_VIRT  = 3'd0;
  localparam logic [FN_W-1:0] FN_GPHYS = 3'd1;

  // control -> datapath
  typedef struct packed {
    logic load;
    logic advance;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic illegal;
    logic twoReq;
  } decode_t;

endpackage

// File: rtl/tlbinv_datapath.sv
module tlbinv_datapath
  import tlbinv_pkg::*;
#(
  parameter int GID_W      = 16,
  parameter int PID_W      = 20,
  parameter int PAGE_W     = 44,
  parameter int PAGE_SHIFT = 12,
  parameter int FN_LSB     = 0,
  parameter int AV_BIT     = 8,
  parameter int PV_BIT     = 9,
  parameter int GV_BIT     = 10,
  parameter int PID_LSB    = 12,
  parameter int GID_LSB    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [63:0]       cmdWord0,
  input  logic [63:0]       cmdWord1,
  output decode_t           decoded,
  output logic [MASK_W-1:0] reqMask,
  output logic [GID_W-1:0]  reqGuestId,
  output logic [PID_W-1:0]  reqProcId,
  output logic [PAGE_W-1:0] reqPage,
  output xlat_tag_e         reqTag
);

  localparam int ADDR_W = 66;

  logic [FN_W-1:0]   fnCode;
  logic              guestValid, procValid, addrValid;
  logic              isVirt, isGphys;
  logic [MASK_W-1:0] nextMask;
  xlat_tag_e         nextTag;
  logic [ADDR_W-1:0] fullAddr;

  assign fnCode     = cmdWord0[FN_LSB +: FN_W];
  assign guestValid = cmdWord0[GV_BIT];
  assign procValid  = cmdWord0[PV_BIT];
  assign addrValid  = cmdWord0[AV_BIT];
  assign isVirt     = (fnCode == FN_VIRT);
  assign isGphys    = (fnCode == FN_GPHYS);
  assign fullAddr   = {cmdWord1, 2'b00};

  always_comb begin
    decoded.illegal = !(isVirt || isGphys) || (isGphys && procValid);
    decoded.twoReq  = isGphys;
    nextMask        = '0;
    if (isGphys) begin
      nextMask[MB_GUEST] = guestValid;
      nextMask[MB_ADDR]  = guestValid && addrValid;
      nextTag            = TAG_GSTAGE;
    end else begin
      nextMask[MB_GUEST] = guestValid;
      nextMask[MB_PROC]  = procValid;
      nextMask[MB_ADDR]  = addrValid;
      nextTag            = guestValid ? TAG_NESTED : TAG_SINGLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqMask    <= '0;
      reqGuestId <= '0;
      reqProcId  <= '0;
      reqPage    <= '0;
      reqTag     <= TAG_BYPASS;
    end else if (strobes.load) begin
      reqMask    <= nextMask;
      reqGuestId <= cmdWord0[GID_LSB +: GID_W];
      reqProcId  <= cmdWord0[PID_LSB +: PID_W];
      reqPage    <= fullAddr[PAGE_SHIFT +: PAGE_W];
      reqTag     <= nextTag;
    end else if (strobes.advance) begin
      reqTag     <= TAG_NESTED;
    end
  end

  // single-stage entries carry no guest comparison
  assert_single_noguest_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqTag == TAG_SINGLE) |-> !reqMask[MB_GUEST]);

  // second-stage-only requests never compare the process ID
  assert_gstage_noproc_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqTag == TAG_GSTAGE) |-> !reqMask[MB_PROC]);

endmodule

// File: rtl/tlbinv_control.sv
module tlbinv_control
  import tlbinv_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  output logic    cmdReady,
  input  decode_t decoded,
  output logic    reqValid,
  input  logic    reqReady,
  output strobe_t strobes,
  output logic    illegalPulse,
  output logic    donePulse
);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_FINISH = 2'd3
  } state_e;

  state_e stateQ, stateD;
  logic   badCmdQ, twoPendQ;
  logic   accept;

  assign cmdReady     = (stateQ == ST_IDLE);
  assign accept       = cmdValid && cmdReady;
  assign reqValid     = (stateQ == ST_FIRST) || (stateQ == ST_SECOND);
  assign illegalPulse = (stateQ == ST_FINISH) && badCmdQ;
  assign donePulse    = (stateQ == ST_FINISH) && !badCmdQ;

  always_comb begin
    stateD          = stateQ;
    strobes.load    = 1'b0;
    strobes.advance = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (accept) begin
        strobes.load = 1'b1;
        stateD       = decoded.illegal ? ST_FINISH : ST_FIRST;
      end
      ST_FIRST: if (reqReady) begin
        if (twoPendQ) begin
          strobes.advance = 1'b1;
          stateD          = ST_SECOND;
        end else begin
          stateD = ST_FINISH;
        end
      end
      ST_SECOND: if (reqReady) stateD = ST_FINISH;
      ST_FINISH: stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      badCmdQ  <= 1'b0;
      twoPendQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (accept) begin
        badCmdQ  <= decoded.illegal;
        twoPendQ <= decoded.twoReq;
      end
    end
  end

  assert_accept_closes_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  assert_hold_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> reqValid);

  assert_pulse_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(illegalPulse && donePulse));

  assert_pulse_then_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (illegalPulse || donePulse) |=> (cmdReady && !illegalPulse && !donePulse));

  assert_illegal_noreq_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && decoded.illegal) |=> !reqValid);

endmodule

// File: rtl/tlb_inval_decoder.sv
module tlb_inval_decoder
  import tlbinv_pkg::*;
#(
  parameter int GID_W      = 16,
  parameter int PID_W      = 20,
  parameter int PAGE_W     = 44,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [63:0]       cmdWord0,
  input  logic [63:0]       cmdWord1,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [MASK_W-1:0] reqMask,
  output logic [GID_W-1:0]  reqGuestId,
  output logic [PID_W-1:0]  reqProcId,
  output logic [PAGE_W-1:0] reqPage,
  output logic [1:0]        reqTag,
  output logic              illegalPulse,
  output logic              donePulse
);

  strobe_t   strobes;
  decode_t   decoded;
  xlat_tag_e tagInt;

  assign reqTag = tagInt;

  tlbinv_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdValid     (cmdValid),
    .cmdReady     (cmdReady),
    .decoded      (decoded),
    .reqValid     (reqValid),
    .reqReady     (reqReady),
    .strobes      (strobes),
    .illegalPulse (illegalPulse),
    .donePulse    (donePulse)
  );

  tlbinv_datapath #(
    .GID_W      (GID_W),
    .PID_W      (PID_W),
    .PAGE_W     (PAGE_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cmdWord0   (cmdWord0),
    .cmdWord1   (cmdWord1),
    .decoded    (decoded),
    .reqMask    (reqMask),
    .reqGuestId (reqGuestId),
    .reqProcId  (reqProcId),
    .reqPage    (reqPage),
    .reqTag     (tagInt)
  );

  assert_fields_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=>
      $stable({reqMask, reqGuestId, reqProcId, reqPage, reqTag}));

  assert_nested_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && tagInt == TAG_GSTAGE) |=>
      (reqValid && tagInt == TAG_NESTED));

endmodule

// File: tb/sim_tlb_inval_decoder.sv
`timescale 1ns/1ps
module sim_tlb_inval_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [63:0] cmdWord0 = '0;
  logic [63:0] cmdWord1 = '0;
  logic        reqValid;
  logic        reqReady = 1'b0;
  logic [2:0]  reqMask;
  logic [15:0] reqGuestId;
  logic [19:0] reqProcId;
  logic [43:0] reqPage;
  logic [1:0]  reqTag;
  logic        illegalPulse, donePulse;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tlb_inval_decoder u0 (.*);

  // captured results of one command
  int          nReq, nIll, nDone;
  bit          readyLeak, holdBad;
  logic [2:0]  gMask [2];
  logic [1:0]  gTag  [2];
  logic [15:0] gGid  [2];
  logic [19:0] gPid  [2];
  logic [43:0] gPage [2];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk0(input logic [2:0] fn, input bit gv, input bit av,
                                      input bit pv, input logic [15:0] gid, input logic [19:0] pid);
    logic [63:0] w = '0;
    w[2:0] = fn; w[8] = av; w[9] = pv; w[10] = gv;
    w[31:12] = pid; w[47:32] = gid;
    return w;
  endfunction

  function automatic logic [43:0] expPage(input logic [63:0] w1);
    logic [63:0] a = (w1 << 2) & ~64'hFFF;
    return a[55:12];
  endfunction

  task automatic runCmd(input logic [63:0] w0, input logic [63:0] w1, input int stall);
    int stallLeft = stall;
    bit ended = 0;
    bit holdSet = 0;
    logic [84:0] snap = '0;
    nReq = 0; nIll = 0; nDone = 0; readyLeak = 0; holdBad = 0;
    @(negedge clk);
    cmdValid = 1'b1; cmdWord0 = w0; cmdWord1 = w1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    for (int c = 0; c < 30 && !ended; c++) begin
      if (illegalPulse) nIll++;
      if (donePulse) nDone++;
      if (illegalPulse || donePulse) ended = 1;
      else if (cmdReady) readyLeak = 1;
      if (reqValid) begin
        if (stallLeft > 0) begin
          reqReady = 1'b0;
          stallLeft--;
          if (!holdSet) begin
            snap = {reqMask, reqTag, reqGuestId, reqProcId, reqPage};
            holdSet = 1;
          end else if (snap != {reqMask, reqTag, reqGuestId, reqProcId, reqPage}) holdBad = 1;
        end else begin
          reqReady = 1'b1;
          if (holdSet && snap != {reqMask, reqTag, reqGuestId, reqProcId, reqPage}) holdBad = 1;
          holdSet = 0;
          if (nReq < 2) begin
            gMask[nReq] = reqMask; gTag[nReq] = reqTag; gGid[nReq] = reqGuestId;
            gPid[nReq] = reqProcId; gPage[nReq] = reqPage;
          end
          nReq++;
          stallLeft = stall;
        end
      end else begin
        reqReady = 1'b0;
        if (holdSet) holdBad = 1;
      end
      @(negedge clk);
    end
    reqReady = 1'b0;
    if (illegalPulse) nIll++;
    if (donePulse) nDone++;
    check(cmdReady, "R1 ready after end", {63'd0, cmdReady}, 64'd1);
    check(!readyLeak, "R1 ready low while busy", {63'd0, readyLeak}, 64'd0);
  endtask

  task automatic expectOne(input string req, input logic [63:0] w0, input logic [63:0] w1,
                           input logic [2:0] mask, input logic [1:0] tag);
    runCmd(w0, w1, 0);
    check(nReq == 1, {req, " request count"}, nReq, 1);
    check(gMask[0] == mask, {req, " mask"}, gMask[0], mask);
    check(gTag[0] == tag, {req, " tag"}, gTag[0], tag);
    check(gGid[0] == w0[47:32] && gPid[0] == w0[31:12], "R8 ids", {gGid[0], gPid[0]}, {w0[47:32], w0[31:12]});
    check(gPage[0] == expPage(w1), "R8 page", gPage[0], expPage(w1));
    check(nDone == 1 && nIll == 0, "R10 done pulse", {nDone[31:0], nIll[31:0]}, {32'd1, 32'd0});
  endtask

  task automatic testReset();
    check(cmdReady && !reqValid && !illegalPulse && !donePulse, "R1 reset state",
          {cmdReady, reqValid, illegalPulse, donePulse}, 4'b1000);
  endtask

  task automatic testVirtGuest();
    expectOne("R6 all flags", mk0(3'd0, 1, 1, 1, 16'h1234, 20'hABCDE), 64'h0000_1234_5678_9ABC, 3'b111, 2'd3);
    expectOne("R6 guest only", mk0(3'd0, 1, 0, 0, 16'h00F1, 20'h00055), 64'h003F_FFFF_FFFF_FFFF, 3'b001, 2'd3);
  endtask

  task automatic testVirtNoGuest();
    expectOne("R7 proc only", mk0(3'd0, 0, 0, 1, 16'hBEEF, 20'h12345), 64'h0000_0000_0000_0400, 3'b010, 2'd1);
    expectOne("R7 nothing", mk0(3'd0, 0, 0, 0, 16'h0001, 20'h00001), 64'h1111_2222_3333_4444, 3'b000, 2'd1);
    expectOne("R7 addr only", mk0(3'd0, 0, 1, 0, 16'h7777, 20'hFFFFF), 64'h0000_0000_0000_03FF, 3'b100, 2'd1);
  endtask

  task automatic testGphys(input string req, input bit gv, input bit av, input logic [2:0] mask, input int stall);
    logic [63:0] w0 = mk0(3'd1, gv, av, 0, 16'hCAFE, 20'h00ABC);
    logic [63:0] w1 = 64'h0012_3456_789A_BCDE;
    runCmd(w0, w1, stall);
    check(nReq == 2, {req, " R4 two requests"}, nReq, 2);
    check(gTag[0] == 2'd2 && gTag[1] == 2'd3, {req, " R4 tag order"}, {gTag[0], gTag[1]}, 4'b1011);
    check(gMask[0] == mask && gMask[1] == mask, {req, " R5 mask"}, {gMask[0], gMask[1]}, {mask, mask});
    check(gPage[1] == expPage(w1) && gGid[1] == 16'hCAFE, {req, " R4 same fields"}, gPage[1], expPage(w1));
    check(!holdBad, {req, " R9 hold under stall"}, {63'd0, holdBad}, 64'd0);
    check(nDone == 1 && nIll == 0, {req, " R10 done"}, {nDone[31:0], nIll[31:0]}, {32'd1, 32'd0});
  endtask

  task automatic testIllegal(input string req, input logic [63:0] w0);
    runCmd(w0, 64'h55, 0);
    check(nReq == 0, {req, " no request"}, nReq, 0);
    check(nIll == 1 && nDone == 0, {req, " R10 illegal pulse only"}, {nIll[31:0], nDone[31:0]}, {32'd1, 32'd0});
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testVirtGuest();
    testVirtNoGuest();
    testGphys("gv av", 1, 1, 3'b101, 0);
    testGphys("gv only stall", 1, 0, 3'b001, 2);
    testGphys("av without gv", 0, 1, 3'b000, 1);
    testIllegal("R3 gphys with pv", mk0(3'd1, 1, 1, 1, 16'h1, 20'h2));
    testIllegal("R2 fn 5", mk0(3'd5, 1, 0, 0, 16'h3, 20'h4));
    testIllegal("R2 fn 2", mk0(3'd2, 0, 0, 0, 16'h0, 20'h0));
    expectOne("R6 after illegal", mk0(3'd0, 1, 0, 1, 16'h0042, 20'h00099), 64'h2, 3'b011, 2'd3);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule